// File: doc/BRIEF.md
# Masked Key-Sense Interrupt Combiner

This block merges eight key-sense input pins into one interrupt request line for a priority controller. Every pin passes through a two-flop synchroniser. A per-pin mask bit then decides whether the pin can take part. A mask bit of 0 lets the pin through and a mask bit of 1 blocks it. All pins that pass the mask share one channel. That channel has a single enable bit, a single sense setting and a single status flag.

The channel senses in one of two ways. In low-level mode the request is on for as long as any enabled pin is low. In falling-edge mode a high-to-low transition on any enabled pin sets a sticky status flag. The flag stays set until software writes a clear command. Software sets the mask, the enable, the sense mode and the clear command through a small register write port.

Top module: `keysense_irq_comb`

## Requirements
- R1: After reset, `irq_req` is 0, every mask bit is 1, the channel enable is 0, the sense mode is low-level and the status flag is clear. With the reset mask in place, a low pin raises no request.
- R2: A change on a pin reaches the low-level request after exactly two rising clock edges, because each pin goes through a two-flop synchroniser.
- R3: A pin whose mask bit is 1 never raises the request in either mode and never sets the status flag.
- R4: A pin whose mask bit is 0 takes part in the request. The request is the OR over all enabled pins. A mask write takes effect from the clock edge that captures it.
- R5: While the channel enable is 0, `irq_req` is 0. Falling edges are still recorded in the flag, so setting the enable later raises `irq_req` at once.
- R6: In falling-edge mode, a high-to-low transition on an enabled synchronised pin sets the flag. `irq_req` rises three rising edges after the pin falls.
- R7: The flag holds until a write to address 2 with data bit 0 = 1. A write to address 2 with bit 0 = 0 has no effect. A rising pin has no effect either.
- R8: In low-level mode, `irq_req` follows the enabled pins with no latching. It drops two edges after the last enabled low pin returns high.
- R9: When a clear write and a new falling edge land on the same clock edge, the flag ends up set.
- R10: Unmasking a pin that is already low does not set the flag in falling-edge mode. It does raise the request in low-level mode.
- R11: The register map is as follows. Address 0 holds the mask (data bit i belongs to pin i). Address 1 holds the control bits: bit 0 is the enable and bit 1 is the sense mode (1 = falling edge, 0 = low level). Address 2 is the clear command. Address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| key_in | input | 8 | Asynchronous key-sense pins, idle high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| irq_req | output | 1 | Shared interrupt request to the priority controller |

## Verification
The hardest case to reach is a clear command that falls on the very clock edge where a new falling edge is detected. Landing on it means counting the synchroniser and edge-history registers between the pin and the flag. The stimulus pulls a pin low, waits exactly two falling clock edges, and then holds the clear write across the third rising edge. It checks that the request is still asserted afterwards. A second difficult case is unmasking a pin that is already low. The pin is held low while masked until its edge history has settled, and only then is it unmasked. The stimulus does this in both sense modes.

// File: rtl/keysense_pkg.sv
package keysense_pkg;

  localparam int unsigned KS_ADDR_W = 2;

  localparam logic [KS_ADDR_W-1:0] KS_ADDR_MASK  = 2'd0;
  localparam logic [KS_ADDR_W-1:0] KS_ADDR_CTRL  = 2'd1;
  localparam logic [KS_ADDR_W-1:0] KS_ADDR_CLEAR = 2'd2;

  localparam int unsigned KS_CTRL_EN_BIT   = 0;
  localparam int unsigned KS_CTRL_MODE_BIT = 1;

  typedef enum logic {
    SENSE_LOW  = 1'b0,
    SENSE_FALL = 1'b1
  } sense_e;

endpackage

// File: rtl/keysense_rst_sync.sv
module keysense_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_q_n = chain_q[STAGES-1];

endmodule

// File: rtl/keysense_sync.sv
module keysense_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_async,
  output logic [WIDTH-1:0] pin_sync
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] stage_q;
    logic [STAGES-1:0] stage_d;

    always_comb begin
      stage_d = {stage_q[STAGES-2:0], pin_async[b]};
    end

    // Idle level of a key-sense pin is high, so the chain resets to ones.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q <= '1;
      end else begin
        stage_q <= stage_d;
      end
    end

    assign pin_sync[b] = stage_q[STAGES-1];
  end

endmodule

// File: rtl/keysense_regs.sv
module keysense_regs
  import keysense_pkg::*;
#(
  parameter int unsigned N_KEYS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [KS_ADDR_W-1:0] wr_addr,
  input  logic [N_KEYS-1:0]    wr_data,
  output logic [N_KEYS-1:0]    mask_q,
  output logic                 en_q,
  output sense_e               mode_q,
  output logic                 clr_pulse
);

  logic              mask_we;
  logic              ctrl_we;
  logic [N_KEYS-1:0] mask_d;
  logic              en_d;
  sense_e            mode_d;

  always_comb begin
    mask_we   = wr_en && (wr_addr == KS_ADDR_MASK);
    ctrl_we   = wr_en && (wr_addr == KS_ADDR_CTRL);
    clr_pulse = wr_en && (wr_addr == KS_ADDR_CLEAR) && wr_data[0];

    mask_d = mask_q;
    en_d   = en_q;
    mode_d = mode_q;
    if (mask_we) begin
      mask_d = wr_data;
    end
    if (ctrl_we) begin
      en_d   = wr_data[KS_CTRL_EN_BIT];
      mode_d = sense_e'(wr_data[KS_CTRL_MODE_BIT]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      en_q   <= 1'b0;
      mode_q <= SENSE_LOW;
    end else begin
      mask_q <= mask_d;
      en_q   <= en_d;
      mode_q <= mode_d;
    end
  end

endmodule

// File: rtl/keysense_detect.sv
module keysense_detect #(
  parameter int unsigned N_KEYS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_KEYS-1:0] pin_sync,
  input  logic [N_KEYS-1:0] mask,
  output logic              fall_hit,
  output logic              level_hit
);

  logic [N_KEYS-1:0] prev_q;
  logic [N_KEYS-1:0] prev_d;
  logic [N_KEYS-1:0] fall_vec;
  logic [N_KEYS-1:0] low_vec;

  // History follows the pins whether masked or not, so unmasking a pin
  // that is already low sees no transition.
  always_comb begin
    prev_d    = pin_sync;
    fall_vec  = prev_q & ~pin_sync & ~mask;
    low_vec   = ~pin_sync & ~mask;
    fall_hit  = |fall_vec;
    level_hit = |low_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '1;
    end else begin
      prev_q <= prev_d;
    end
  end

endmodule

// File: rtl/keysense_irq_comb.sv
module keysense_irq_comb
  import keysense_pkg::*;
#(
  parameter int unsigned N_KEYS      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_KEYS-1:0]    key_in,
  input  logic                 wr_en,
  input  logic [KS_ADDR_W-1:0] wr_addr,
  input  logic [N_KEYS-1:0]    wr_data,
  output logic                 irq_req
);

  logic              rst_q_n;
  logic [N_KEYS-1:0] sync_key;
  logic [N_KEYS-1:0] mask_q;
  logic              en_q;
  sense_e            mode_q;
  logic              clr_pulse;
  logic              fall_hit;
  logic              level_hit;
  logic              flag_q;
  logic              flag_d;
  logic              fall_mode;

  keysense_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  keysense_sync #(.WIDTH(N_KEYS), .STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .pin_async (key_in),
    .pin_sync  (sync_key)
  );

  keysense_regs #(.N_KEYS(N_KEYS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .mask_q    (mask_q),
    .en_q      (en_q),
    .mode_q    (mode_q),
    .clr_pulse (clr_pulse)
  );

  keysense_detect #(.N_KEYS(N_KEYS)) u_det (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .pin_sync  (sync_key),
    .mask      (mask_q),
    .fall_hit  (fall_hit),
    .level_hit (level_hit)
  );

  // A new edge takes priority over a clear on the same edge.
  always_comb begin
    fall_mode = (mode_q == SENSE_FALL);
    flag_d    = flag_q;
    if (fall_mode && fall_hit) begin
      flag_d = 1'b1;
    end else if (clr_pulse) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign irq_req = en_q & (fall_mode ? flag_q : level_hit);

endmodule

// File: rtl/keysense_irq_comb_chk.sv
module keysense_irq_comb_chk #(
  parameter int unsigned N_KEYS = 8
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              irq_req,
  input logic [N_KEYS-1:0] sync_key,
  input logic [N_KEYS-1:0] mask_q,
  input logic              en_q,
  input logic              fall_mode,
  input logic              flag_q,
  input logic              clr_pulse,
  input logic              fall_hit
);

  a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_q_n)
    !en_q |-> !irq_req);

  a_r3_all_masked_no_flag: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((&mask_q) && !flag_q) |=> !flag_q);

  a_r3_all_masked_no_level: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((&mask_q) && !fall_mode) |-> !irq_req);

  a_r6_edge_sets_flag: assert property (@(posedge clk) disable iff (!rst_q_n)
    (fall_mode && fall_hit) |=> flag_q);

  a_r7_flag_holds: assert property (@(posedge clk) disable iff (!rst_q_n)
    (flag_q && !clr_pulse) |=> flag_q);

  a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_q_n)
    (clr_pulse && !(fall_mode && fall_hit)) |=> !flag_q);

  a_r8_level_follows: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!fall_mode && en_q) |-> (irq_req == (|(~sync_key & ~mask_q))));

  a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_q_n)
    (clr_pulse && fall_mode && fall_hit) |=> flag_q);

endmodule

bind keysense_irq_comb keysense_irq_comb_chk #(.N_KEYS(N_KEYS)) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .irq_req   (irq_req),
  .sync_key  (sync_key),
  .mask_q    (mask_q),
  .en_q      (en_q),
  .fall_mode (fall_mode),
  .flag_q    (flag_q),
  .clr_pulse (clr_pulse),
  .fall_hit  (fall_hit)
);

// File: tb/tb_keysense_irq_comb.sv
module tb_keysense_irq_comb;

  logic       clk;
  logic       rst_n;
  logic [7:0] key_in;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       irq_req;

  int checks = 0;
  int errors = 0;

  keysense_irq_comb dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .key_in  (key_in),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .irq_req (irq_req)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic exp);
    checks++;
    if (irq_req !== exp) begin
      errors++;
      $display("FAIL %s: irq_req=%0b expected %0b", req, irq_req, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_key(input int idx, input logic v);
    @(negedge clk);
    key_in[idx] = v;
  endtask

  task automatic t_reset;
    chk("R1 reset request", 1'b0);
    wr(2'd1, 8'h01);            // enable, low-level mode, mask still reset value
    key_in = 8'h00;
    wait_neg(4);
    chk("R1 reset mask blocks low pins", 1'b0);
    key_in = 8'hFF;
    wait_neg(4);
  endtask

  task automatic t_level;
    wr(2'd0, 8'hFE);
    set_key(0, 1'b0);
    wait_neg(1);
    chk("R2 one edge after pin falls", 1'b0);
    wait_neg(1);
    chk("R2 R8 two edges after pin falls", 1'b1);
    set_key(0, 1'b1);
    wait_neg(1);
    chk("R8 still synchronising", 1'b1);
    wait_neg(1);
    chk("R8 level released", 1'b0);
    set_key(3, 1'b0);
    wait_neg(4);
    chk("R3 masked pin in level mode", 1'b0);
    wr(2'd0, 8'hF6);
    chk("R4 unmask takes effect at once", 1'b1);
    set_key(3, 1'b1);
    wait_neg(3);
  endtask

  task automatic t_edge;
    wr(2'd0, 8'hFE);
    wr(2'd1, 8'h03);
    set_key(0, 1'b0);
    wait_neg(2);
    chk("R6 not yet flagged", 1'b0);
    wait_neg(1);
    chk("R6 flag after three edges", 1'b1);
    set_key(0, 1'b1);
    wait_neg(4);
    chk("R7 flag holds after pin rises", 1'b1);
    wr(2'd2, 8'h00);
    chk("R7 clear write with bit0=0 ignored", 1'b1);
    wr(2'd3, 8'hFF);
    chk("R11 address 3 has no effect", 1'b1);
    wr(2'd2, 8'h01);
    chk("R7 clear write", 1'b0);
    set_key(5, 1'b0);
    wait_neg(5);
    chk("R3 masked pin edge ignored", 1'b0);
    set_key(5, 1'b1);
    wait_neg(3);
  endtask

  task automatic t_enable;
    wr(2'd1, 8'h02);            // falling-edge mode, disabled
    set_key(0, 1'b0);
    wait_neg(5);
    chk("R5 disabled channel quiet", 1'b0);
    wr(2'd1, 8'h03);
    chk("R5 recorded edge shows on enable", 1'b1);
    set_key(0, 1'b1);
    wr(2'd2, 8'h01);
    wait_neg(3);
    chk("R5 cleared", 1'b0);
  endtask

  task automatic t_unmask_low;
    wr(2'd0, 8'hFF);
    set_key(1, 1'b0);
    wait_neg(4);
    wr(2'd0, 8'hFD);
    wait_neg(4);
    chk("R10 unmasking low pin sets no flag", 1'b0);
    wr(2'd1, 8'h01);
    chk("R10 low-level mode sees the low pin", 1'b1);
    set_key(1, 1'b1);
    wait_neg(3);
    chk("R8 low pin released", 1'b0);
    wr(2'd0, 8'hFE);
    wr(2'd1, 8'h03);
  endtask

  task automatic t_set_wins;
    wr(2'd2, 8'h01);
    chk("R9 flag starts clear", 1'b0);
    @(negedge clk);
    key_in[0] = 1'b0;           // N0
    @(negedge clk);             // N1
    @(negedge clk);             // N2: detection pending for next edge
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h01;
    @(negedge clk);             // N3
    wr_en = 1'b0;
    chk("R9 edge beats simultaneous clear", 1'b1);
    key_in[0] = 1'b1;
    wr(2'd2, 8'h01);
    chk("R9 later clear", 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; key_in = 8'hFF; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wait_neg(4);
    t_reset();
    t_level();
    t_edge();
    t_enable();
    t_unmask_low();
    t_set_wins();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule